// File: doc/BRIEF.md
# SD Block DMA Engine with Boundary Pause

This block moves fixed-length data blocks between the card-side data path of an SD host and system memory, one 32-bit word per cycle, starting from a programmed address and counting the remaining blocks down. Software loads a start address and a block geometry, then writes the transfer mode. In card-to-memory mode the engine turns each word from the card stream into a memory write. In memory-to-card mode it turns each memory read into a word on the card stream.

The address space is split into buffers whose size is a power of two that software selects. Whenever the next word address would land on the start of a new buffer and data still remains, the engine stops and raises its DMA-pause flag. Software then rewrites the address register to continue, which allows a scattered set of buffers to be filled. The block count carries on across these pauses. After the final word the engine raises transfer-complete and can ask for an automatic stop command.

Top module: `sddma_engine`

## Requirements
- R1: Register map by word index on `regAddr`: 0 address, 1 geometry, 2 mode, 3 status, 4 reset. Each transferred word uses the current address, which then advances by 4. Index 0 reads back the current address.
- R2: Geometry fields are: block length in bytes at bits 11:0 (a multiple of 4), boundary code at bits 14:12, and block count at bits 31:16. The count drops by one as each block's last word moves and can be read back at any time.
- R3: If a word moves and the next address is a multiple of the buffer size while data remains, the engine sets status bit 3 and `irqDma`. It then issues no memory request until index 0 is written, and resumes from the newly written address.
- R4: The buffer size is 4096 bytes shifted left by the boundary code, so codes 0 to 7 give 4 KB to 512 KB.
- R5: When the last word of the last block moves, the engine sets status bit 1 and `irqDone` and goes idle. If that word also reaches a boundary, only bit 1 is set.
- R6: If mode bit 2 is set, `stopReq` pulses high for exactly one cycle, in the cycle after the final word. If mode bit 2 is clear, `stopReq` does not pulse.
- R7: A transfer starts only when a mode write has both bit 0 (DMA enable) and bit 1 (count enable) set, the engine is idle, and the count is non-zero. Mode bit 4 set selects card-to-memory; bit 4 clear selects memory-to-card.
- R8: In memory-to-card mode, each memory read word appears on `cardOutData` in address order, and no memory write is issued.
- R9: While a transfer is running, writes to the geometry and mode registers are ignored. Writes to the address register are ignored unless the engine is paused.
- R10: Writing bit 2 of register 4 aborts at once. The engine returns to idle and the pause flag clears. The block count keeps its current value, and a later address write does not restart the transfer.
- R11: Status bits 1 and 3 are cleared by writing 1 to them.
- R12: Stalls on `memReady`, `cardInValid` or `cardOutReady` hold the address and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory byte address |
| memWData | output | 32 | Memory write data |
| memReady | input | 1 | Memory accepts request (read data valid) |
| memRData | input | 32 | Memory read data |
| cardInValid | input | 1 | Card-to-memory word valid |
| cardInReady | output | 1 | Card-to-memory word taken |
| cardInData | input | 32 | Card-to-memory word |
| cardOutValid | output | 1 | Memory-to-card word valid |
| cardOutReady | input | 1 | Card side accepts word |
| cardOutData | output | 32 | Memory-to-card word |
| irqDma | output | 1 | Boundary pause flag |
| irqDone | output | 1 | Transfer complete flag |
| stopReq | output | 1 | Automatic stop command request pulse |

## Verification
Two events can fall on the same edge: reaching a buffer boundary and finishing the final block. The bench causes this by placing a single four-word block so that its last word ends exactly at a 4 KB boundary. It then expects the complete flag alone, with the pause flag low, the engine idle and no further memory requests. A second case with boundary code 1 crosses a 4 KB line that is not an 8 KB line, and the engine must not pause there.

// File: rtl/sddma_pkg.sv
package sddma_pkg;

  localparam int REG_W = 32;

  // register word indices
  localparam logic [2:0] REG_SYSADDR = 3'd0;
  localparam logic [2:0] REG_GEOM    = 3'd1;
  localparam logic [2:0] REG_MODE    = 3'd2;
  localparam logic [2:0] REG_STATUS  = 3'd3;
  localparam logic [2:0] REG_RESET   = 3'd4;

  // mode bit positions
  localparam int MODE_DMA      = 0;
  localparam int MODE_CNTEN    = 1;
  localparam int MODE_AUTOSTOP = 2;
  localparam int MODE_READ     = 4;

  // status and reset bit positions
  localparam int ST_DONE  = 1;
  localparam int ST_PAUSE = 3;
  localparam int RST_DATA = 2;

  localparam int GEOM_CNT_LSB = 16;

  typedef struct packed {
    logic             wrAddr;
    logic             wrGeom;
    logic             wrMode;
    logic             wrStatus;
    logic             wrReset;
    logic [REG_W-1:0] wdata;
  } regWr_t;

  typedef struct packed {
    logic inRun;     // moving words
    logic busy;      // running or paused
    logic clearIdx;  // restart word index
  } dpCtrl_t;

  typedef struct packed {
    logic wordXfer;
    logic lastWord;
    logic lastBlock;
    logic boundaryHit;
    logic cntNonZero;
    logic autoStop;
  } dpStat_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RUN   = 2'd1,
    S_PAUSE = 2'd2
  } xferState_t;

endpackage

// File: rtl/sddma_datapath.sv
module sddma_datapath
  import sddma_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 32,
  parameter int LEN_W         = 12,
  parameter int BND_W         = 3,
  parameter int CNT_W         = 16,
  parameter int BND_BASE_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  regWr_t            regWr,
  input  dpCtrl_t           dpCtrl,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRData,
  input  logic              cardInValid,
  output logic              cardInReady,
  input  logic [DATA_W-1:0] cardInData,
  output logic              cardOutValid,
  input  logic              cardOutReady,
  output logic [DATA_W-1:0] cardOutData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LEN_W-1:0]  blkLen,
  output logic [BND_W-1:0]  bndCode,
  output logic [CNT_W-1:0]  blkCnt,
  output logic [3:0]        modeBits,
  output dpStat_t           dpStat
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BYTE_LOG2  = $clog2(WORD_BYTES);

  logic [LEN_W-1:0]  wordIdx;
  logic [LEN_W-1:0]  wordsPerBlk;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] bndMask;
  logic              modeDma, modeCnt, modeStop, modeRead;
  logic              wordXfer, lastWord, cntLoad;

  assign modeBits = {modeRead, modeStop, modeCnt, modeDma};

  // geometry
  assign wordsPerBlk = blkLen >> BYTE_LOG2;
  assign lastWord    = (wordIdx == (wordsPerBlk - 1'b1));
  assign nextAddr    = curAddr + ADDR_W'(WORD_BYTES);
  assign bndMask     = ({{(ADDR_W-1){1'b0}}, 1'b1} << (BND_BASE_LOG2 + int'(bndCode))) - 1'b1;

  // handshake, one word per cycle, no buffering
  assign memReq       = dpCtrl.inRun && (modeRead ? cardInValid : cardOutReady);
  assign memWe        = dpCtrl.inRun && modeRead;
  assign memAddr      = curAddr;
  assign memWData     = cardInData;
  assign cardInReady  = dpCtrl.inRun && modeRead && memReady;
  assign cardOutValid = dpCtrl.inRun && !modeRead && memReady;
  assign cardOutData  = memRData;
  assign wordXfer     = memReq && memReady;

  assign cntLoad = regWr.wrGeom && !dpCtrl.busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (regWr.wrAddr && !dpCtrl.inRun) begin
      curAddr <= regWr.wdata[ADDR_W-1:0];
    end else if (wordXfer) begin
      curAddr <= nextAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkLen  <= '0;
      bndCode <= '0;
    end else if (cntLoad) begin
      blkLen  <= regWr.wdata[LEN_W-1:0];
      bndCode <= regWr.wdata[LEN_W +: BND_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkCnt <= '0;
    end else if (cntLoad) begin
      blkCnt <= regWr.wdata[GEOM_CNT_LSB +: CNT_W];
    end else if (wordXfer && lastWord) begin
      blkCnt <= blkCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeDma  <= 1'b0;
      modeCnt  <= 1'b0;
      modeStop <= 1'b0;
      modeRead <= 1'b0;
    end else if (regWr.wrMode && !dpCtrl.busy) begin
      modeDma  <= regWr.wdata[MODE_DMA];
      modeCnt  <= regWr.wdata[MODE_CNTEN];
      modeStop <= regWr.wdata[MODE_AUTOSTOP];
      modeRead <= regWr.wdata[MODE_READ];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordIdx <= '0;
    end else if (dpCtrl.clearIdx) begin
      wordIdx <= '0;
    end else if (wordXfer) begin
      wordIdx <= lastWord ? '0 : wordIdx + 1'b1;
    end
  end

  always_comb begin
    dpStat.wordXfer    = wordXfer;
    dpStat.lastWord    = lastWord;
    dpStat.lastBlock   = (blkCnt == CNT_W'(1));
    dpStat.boundaryHit = ((nextAddr & bndMask) == '0);
    dpStat.cntNonZero  = (blkCnt != '0);
    dpStat.autoStop    = modeStop;
  end

  // R1: each moved word advances the address by one word
  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    wordXfer |=> curAddr == ADDR_W'($past(curAddr) + ADDR_W'(WORD_BYTES)));

  // R2: count drops by one when a block's last word moves
  p_count_dec_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wordXfer && lastWord) |=> blkCnt == CNT_W'($past(blkCnt) - 1'b1));

  // R12: without a moved last word or an idle load the count holds
  p_count_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!(wordXfer && lastWord) && !cntLoad) |=> $stable(blkCnt));

  // R8: memory-to-card never writes memory
  p_no_write_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    cardOutValid |-> !memWe);

endmodule

// File: rtl/sddma_ctrl.sv
module sddma_ctrl
  import sddma_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  regWr_t  regWr,
  input  dpStat_t dpStat,
  output dpCtrl_t dpCtrl,
  output logic    dmaFlag,
  output logic    doneFlag,
  output logic    stopReq
);

  xferState_t state, stateNext;
  logic abort, startReq, finalWord, hitPause;

  assign abort     = regWr.wrReset && regWr.wdata[RST_DATA];
  assign startReq  = (state == S_IDLE) && regWr.wrMode &&
                     regWr.wdata[MODE_DMA] && regWr.wdata[MODE_CNTEN] &&
                     dpStat.cntNonZero;
  assign finalWord = (state == S_RUN) && dpStat.wordXfer &&
                     dpStat.lastWord && dpStat.lastBlock;
  assign hitPause  = (state == S_RUN) && dpStat.wordXfer &&
                     dpStat.boundaryHit && !finalWord;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (startReq) stateNext = S_RUN;
      S_RUN: begin
        if (finalWord)     stateNext = S_IDLE;
        else if (hitPause) stateNext = S_PAUSE;
      end
      S_PAUSE: if (regWr.wrAddr) stateNext = S_RUN;
      default: stateNext = S_IDLE;
    endcase
    if (abort) stateNext = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaFlag  <= 1'b0;
      doneFlag <= 1'b0;
      stopReq  <= 1'b0;
    end else begin
      if (abort)
        dmaFlag <= 1'b0;
      else if (hitPause)
        dmaFlag <= 1'b1;
      else if (regWr.wrStatus && regWr.wdata[ST_PAUSE])
        dmaFlag <= 1'b0;

      if (finalWord && !abort)
        doneFlag <= 1'b1;
      else if (regWr.wrStatus && regWr.wdata[ST_DONE])
        doneFlag <= 1'b0;

      stopReq <= finalWord && !abort && dpStat.autoStop;
    end
  end

  always_comb begin
    dpCtrl.inRun    = (state == S_RUN);
    dpCtrl.busy     = (state != S_IDLE);
    dpCtrl.clearIdx = startReq || abort;
  end

  // R3: nothing moves outside the running state
  p_no_move_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_RUN) |-> !dpStat.wordXfer);

  // R5: a final word always ends the transfer, boundary or not
  p_final_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    finalWord |=> (state == S_IDLE) && !$rose(dmaFlag));

  // R6: a stop request only follows completion
  p_stop_after_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |-> doneFlag);

  // R10: data reset returns to idle with the pause flag clear
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (state == S_IDLE) && !dmaFlag);

endmodule

// File: rtl/sddma_engine.sv
module sddma_engine
  import sddma_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 32,
  parameter int LEN_W         = 12,
  parameter int BND_W         = 3,
  parameter int CNT_W         = 16,
  parameter int BND_BASE_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRData,
  input  logic              cardInValid,
  output logic              cardInReady,
  input  logic [DATA_W-1:0] cardInData,
  output logic              cardOutValid,
  input  logic              cardOutReady,
  output logic [DATA_W-1:0] cardOutData,
  output logic              irqDma,
  output logic              irqDone,
  output logic              stopReq
);

  regWr_t            regWr;
  dpCtrl_t           dpCtrl;
  dpStat_t           dpStat;
  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  blkLen;
  logic [BND_W-1:0]  bndCode;
  logic [CNT_W-1:0]  blkCnt;
  logic [3:0]        modeBits;

  always_comb begin
    regWr.wrAddr   = regWrEn && (regAddr == REG_SYSADDR);
    regWr.wrGeom   = regWrEn && (regAddr == REG_GEOM);
    regWr.wrMode   = regWrEn && (regAddr == REG_MODE);
    regWr.wrStatus = regWrEn && (regAddr == REG_STATUS);
    regWr.wrReset  = regWrEn && (regAddr == REG_RESET);
    regWr.wdata    = regWrData;
  end

  sddma_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .BND_W(BND_W),
    .CNT_W(CNT_W), .BND_BASE_LOG2(BND_BASE_LOG2)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .regWr(regWr), .dpCtrl(dpCtrl),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memReady(memReady), .memRData(memRData),
    .cardInValid(cardInValid), .cardInReady(cardInReady), .cardInData(cardInData),
    .cardOutValid(cardOutValid), .cardOutReady(cardOutReady), .cardOutData(cardOutData),
    .curAddr(curAddr), .blkLen(blkLen), .bndCode(bndCode), .blkCnt(blkCnt),
    .modeBits(modeBits), .dpStat(dpStat)
  );

  sddma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .dpStat(dpStat), .dpCtrl(dpCtrl),
    .dmaFlag(irqDma), .doneFlag(irqDone), .stopReq(stopReq)
  );

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      REG_SYSADDR: regRdData[ADDR_W-1:0] = curAddr;
      REG_GEOM: begin
        regRdData[LEN_W-1:0]              = blkLen;
        regRdData[LEN_W +: BND_W]         = bndCode;
        regRdData[GEOM_CNT_LSB +: CNT_W]  = blkCnt;
      end
      REG_MODE: begin
        regRdData[MODE_DMA]      = modeBits[0];
        regRdData[MODE_CNTEN]    = modeBits[1];
        regRdData[MODE_AUTOSTOP] = modeBits[2];
        regRdData[MODE_READ]     = modeBits[3];
      end
      REG_STATUS: begin
        regRdData[ST_DONE]  = irqDone;
        regRdData[ST_PAUSE] = irqDma;
      end
      default: regRdData = '0;
    endcase
  end

endmodule

// File: tb/sddma_engine_tb.sv
module sddma_engine_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq, memWe, memReady;
  logic [31:0] memAddr, memWData, memRData;
  logic        cardInValid = 1'b0, cardInReady;
  logic [31:0] cardInData;
  logic        cardOutValid, cardOutReady = 1'b0;
  logic [31:0] cardOutData;
  logic        irqDma, irqDone, stopReq;
  logic        memStall = 1'b0;

  int checks = 0;
  int fails  = 0;
  int inSeq  = 0;
  int outCnt = 0;
  int stopCnt = 0;
  int memWrCnt = 0;
  logic [31:0] mem [0:4095];
  logic [31:0] outLog [0:63];

  always #5 clk = ~clk;

  sddma_engine u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memReady(memReady), .memRData(memRData),
    .cardInValid(cardInValid), .cardInReady(cardInReady), .cardInData(cardInData),
    .cardOutValid(cardOutValid), .cardOutReady(cardOutReady), .cardOutData(cardOutData),
    .irqDma(irqDma), .irqDone(irqDone), .stopReq(stopReq)
  );

  assign memReady   = memReq && !memStall;
  assign memRData   = mem[memAddr[13:2]];
  assign cardInData = 32'hA000_0000 + 32'(inSeq);

  always @(posedge clk) begin
    if (memReq && memWe && memReady) begin
      mem[memAddr[13:2]] <= memWData;
      memWrCnt <= memWrCnt + 1;
    end
    if (cardInValid && cardInReady) inSeq <= inSeq + 1;
    if (cardOutValid && cardOutReady) begin
      outLog[outCnt[5:0]] <= cardOutData;
      outCnt <= outCnt + 1;
    end
    if (stopReq) stopCnt <= stopCnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [31:0] geom(input int cnt, input int code, input int len);
    return (32'(cnt) << 16) | (32'(code) << 12) | 32'(len);
  endfunction

  task automatic waitDone();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (irqDone) break;
    end
  endtask

  task automatic waitPause();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (irqDma) break;
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    regRead(3'd0, d); chk("R1 reset address", d, 32'h0);
    regRead(3'd1, d); chk("R2 reset geometry", d, 32'h0);
    regRead(3'd3, d); chk("R11 reset status", d, 32'h0);
    chk("R3 reset memReq", {31'b0, memReq}, 32'h0);
  endtask

  task automatic testBasicRead();
    logic [31:0] d;
    int base, stop0;
    cardInValid = 1'b1;
    regWrite(3'd0, 32'h100);
    regWrite(3'd1, geom(3, 0, 16));
    base = inSeq; stop0 = stopCnt;
    regWrite(3'd2, 32'h17);
    waitDone();
    chk("R5 done set", {31'b0, irqDone}, 32'h1);
    chk("R5 no pause", {31'b0, irqDma}, 32'h0);
    regRead(3'd1, d); chk("R2 count to zero", d[31:16], 32'h0);
    regRead(3'd0, d); chk("R1 end address", d, 32'h130);
    for (int i = 0; i < 12; i++)
      chk("R1 card-to-memory data", mem[(32'h100 >> 2) + i], 32'hA000_0000 + 32'(base + i));
    repeat (3) @(negedge clk);
    chk("R6 one stop pulse", 32'(stopCnt - stop0), 32'h1);
    chk("R5 idle after done", {31'b0, memReq}, 32'h0);
    regWrite(3'd3, 32'h2);
    chk("R11 done cleared", {31'b0, irqDone}, 32'h0);
  endtask

  task automatic testBoundary();
    logic [31:0] d;
    int base, stop0;
    regWrite(3'd0, 32'hFE0);
    regWrite(3'd1, geom(5, 0, 16));
    base = inSeq; stop0 = stopCnt;
    regWrite(3'd2, 32'h13);
    waitPause();
    chk("R3 pause at 4KB", {31'b0, irqDma}, 32'h1);
    regRead(3'd1, d); chk("R2 count across pause", d[31:16], 32'h3);
    regRead(3'd0, d); chk("R3 paused address", d, 32'h1000);
    repeat (10) @(negedge clk);
    chk("R3 no words while paused", 32'(inSeq - base), 32'h8);
    chk("R3 no request while paused", {31'b0, memReq}, 32'h0);
    regWrite(3'd3, 32'h8);
    chk("R11 pause cleared", {31'b0, irqDma}, 32'h0);
    regWrite(3'd0, 32'h2000);
    waitDone();
    chk("R5 done after resume", {31'b0, irqDone}, 32'h1);
    regRead(3'd1, d); chk("R2 count zero after resume", d[31:16], 32'h0);
    for (int i = 0; i < 12; i++)
      chk("R3 resumed data", mem[(32'h2000 >> 2) + i], 32'hA000_0000 + 32'(base + 8 + i));
    repeat (3) @(negedge clk);
    chk("R6 no stop without bit 2", 32'(stopCnt - stop0), 32'h0);
    regWrite(3'd3, 32'h2);
  endtask

  task automatic testCoincide();
    logic [31:0] d;
    regWrite(3'd0, 32'hFF0);
    regWrite(3'd1, geom(1, 0, 16));
    regWrite(3'd2, 32'h13);
    waitDone();
    chk("R5 coincide done", {31'b0, irqDone}, 32'h1);
    chk("R5 coincide no pause", {31'b0, irqDma}, 32'h0);
    regRead(3'd0, d); chk("R5 coincide address", d, 32'h1000);
    repeat (4) @(negedge clk);
    chk("R5 coincide idle", {31'b0, memReq}, 32'h0);
    regWrite(3'd3, 32'h2);
  endtask

  task automatic testCodeAndAbortPause();
    logic [31:0] d;
    int base;
    regWrite(3'd0, 32'hFF0);
    regWrite(3'd1, geom(2, 1, 16));
    regWrite(3'd2, 32'h13);
    waitDone();
    chk("R4 8KB ignores 4KB line", {31'b0, irqDma}, 32'h0);
    regRead(3'd0, d); chk("R4 passed 4KB line", d, 32'h1010);
    regWrite(3'd3, 32'h2);
    regWrite(3'd0, 32'h1FF0);
    regWrite(3'd1, geom(2, 1, 16));
    regWrite(3'd2, 32'h13);
    waitPause();
    chk("R4 pause at 8KB", {31'b0, irqDma}, 32'h1);
    regRead(3'd1, d); chk("R4 count at 8KB pause", d[31:16], 32'h1);
    regWrite(3'd4, 32'h4);
    chk("R10 pause cleared by reset", {31'b0, irqDma}, 32'h0);
    regRead(3'd1, d); chk("R10 count kept", d[31:16], 32'h1);
    base = inSeq;
    regWrite(3'd0, 32'h3000);
    repeat (5) @(negedge clk);
    chk("R10 address write no restart", 32'(inSeq - base), 32'h0);
    chk("R10 idle after reset", {31'b0, memReq}, 32'h0);
  endtask

  task automatic testWriteDir();
    int wr0;
    for (int i = 0; i < 8; i++) mem[(32'h300 >> 2) + i] = 32'h5000_0000 + 32'(i);
    outCnt = 0;
    cardOutReady = 1'b1;
    wr0 = memWrCnt;
    regWrite(3'd0, 32'h300);
    regWrite(3'd1, geom(2, 0, 16));
    regWrite(3'd2, 32'h03);
    waitDone();
    @(negedge clk);
    chk("R8 word count out", 32'(outCnt), 32'h8);
    for (int i = 0; i < 8; i++)
      chk("R8 memory-to-card data", outLog[i], 32'h5000_0000 + 32'(i));
    chk("R8 no memory writes", 32'(memWrCnt - wr0), 32'h0);
    chk("R7 direction from bit 4", {31'b0, irqDone}, 32'h1);
    cardOutReady = 1'b0;
    regWrite(3'd3, 32'h2);
  endtask

  task automatic testEnableGate();
    logic [31:0] d;
    int base;
    base = inSeq;
    regWrite(3'd0, 32'h600);
    regWrite(3'd1, geom(2, 0, 16));
    regWrite(3'd2, 32'h11);
    repeat (6) @(negedge clk);
    chk("R7 no start without count enable", 32'(inSeq - base), 32'h0);
    regWrite(3'd2, 32'h12);
    repeat (6) @(negedge clk);
    chk("R7 no start without DMA enable", 32'(inSeq - base), 32'h0);
    regRead(3'd1, d); chk("R7 count untouched", d[31:16], 32'h2);
  endtask

  task automatic testIgnoreStallAbort();
    logic [31:0] d;
    int base;
    cardInValid = 1'b0;
    regWrite(3'd0, 32'h400);
    regWrite(3'd1, geom(4, 0, 16));
    regWrite(3'd2, 32'h13);
    regWrite(3'd1, geom(9, 0, 16));
    regRead(3'd1, d); chk("R9 geometry write ignored", d[31:16], 32'h4);
    regWrite(3'd0, 32'h800);
    regRead(3'd0, d); chk("R9 address write ignored", d, 32'h400);
    regWrite(3'd2, 32'h03);
    regRead(3'd2, d); chk("R9 mode write ignored", d, 32'h13);
    memStall = 1'b1; cardInValid = 1'b1;
    repeat (5) @(negedge clk);
    regRead(3'd0, d); chk("R12 memory stall holds address", d, 32'h400);
    @(negedge clk);
    memStall = 1'b0;
    base = inSeq;
    repeat (5) @(negedge clk);
    cardInValid = 1'b0;
    chk("R12 words after stall", 32'(inSeq - base), 32'h5);
    regRead(3'd1, d); chk("R2 count mid transfer", d[31:16], 32'h3);
    regRead(3'd0, d); chk("R1 mid address", d, 32'h414);
    regWrite(3'd4, 32'h4);
    cardInValid = 1'b1;
    base = inSeq;
    repeat (5) @(negedge clk);
    chk("R10 abort stops words", 32'(inSeq - base), 32'h0);
    regRead(3'd1, d); chk("R10 count kept on abort", d[31:16], 32'h3);
    chk("R10 no done on abort", {31'b0, irqDone}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    fork
      begin
        testReset();
        testBasicRead();
        testBoundary();
        testCoincide();
        testCodeAndAbortPause();
        testWriteDir();
        testEnableGate();
        testIgnoreStallAbort();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule